// File: doc/BRIEF.md
# Tag Reply Window Timing Monitor

This block watches a digitized interrogator envelope and a tag-response line, both already sampled on one reference clock. It measures how many clock ticks pass from the interrogator's most recent rising edge to the first rising edge of the tag response. It then sorts that delay against an acceptance window: a reply is early, in the window, or late. A missing reply is treated as late once the count passes the upper limit.

The window is computed at run time from configuration inputs. These are the calibration symbol length in ticks, the link pulse period in ticks, a frequency-tolerance fraction, and a fixed safety margin in ticks. The nominal delay is the larger of the calibration length and ten link periods. The tolerance stretches the nominal delay in both directions, and the margin widens it further. One configuration covers a tolerance range of roughly 4 % to 22 %, and that range is where the window check is used.

Each measurement produces one result. The result is a single-cycle valid strobe, exactly one class flag and the measured tick count.

Top module: `tag_reply_window_monitor`

## Requirements
- R1: The nominal delay is the larger of `cfg_rtcal` and ten times `cfg_link_period`, both in clock ticks.
- R2: With `cfg_tol` an unsigned fraction in 1/256 units, let dev = floor(nominal × cfg_tol / 256). The lower limit is nominal − dev − `cfg_margin`, clamped at 0. The upper limit is nominal + dev + `cfg_margin`. The limits follow a configuration change one clock later.
- R3: The delay d is the number of clock edges from the edge where a rising envelope is first sampled to the edge where a rising response is first sampled. A reply with lower ≤ d ≤ upper raises `res_ok`, and `res_count` carries d.
- R4: A reply with d below the lower limit raises `res_early`, and `res_count` carries d.
- R5: If no response rise has been sampled by the edge at which the count reaches upper+1, the block reports `res_late` with `res_count` = upper+1 and returns to idle. A reply arriving exactly at d = upper+1 is reported the same way.
- R6: A new envelope rise while a measurement is in progress restarts the count, so only the last envelope rise before the reply is used.
- R7: A response rise while no measurement is in progress produces no result.
- R8: `res_valid` is high for exactly one cycle per result. While it is high, exactly one of `res_early`, `res_ok` and `res_late` is set. While it is low, all three flags and `res_count` are 0.
- R9: After reset, all result outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| env_in | input | 1 | Digitized interrogator envelope |
| resp_in | input | 1 | Tag-response line |
| cfg_rtcal | input | TICK_W | Calibration symbol length, ticks |
| cfg_link_period | input | TICK_W | Link pulse period, ticks |
| cfg_tol | input | TOL_W | Frequency tolerance, unsigned fraction of 256 |
| cfg_margin | input | TICK_W | Fixed margin, ticks |
| res_valid | output | 1 | One-cycle result strobe |
| res_early | output | 1 | Reply came before the window |
| res_ok | output | 1 | Reply inside the window |
| res_late | output | 1 | Reply after the window, or no reply |
| res_count | output | TICK_W+6 | Measured delay in ticks |

## Verification
The first window uses a link-period-dominated nominal delay. Replies are placed one tick on each side of both limits and at an interior point, which separates the three classes and exposes off-by-one counting. A second window is calibration-dominated and has a small tolerance, which shows that the maximum selection and the truncating multiply pick the right operand. A third uses full tolerance with a large margin, so the lower limit clamps to zero. Replies that never come, double envelope pulses, and response pulses with no preceding envelope separate the timeout, restart and ignore paths.

// File: rtl/rwm_pkg.sv
// Shared definitions for the tag reply window monitor.
// Assumes a single clock domain; all widths are derived from TICK_W.
package rwm_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } rwm_state_e;

    // Extra bits needed so that 10*period*(1+tol)+margin never wraps.
    localparam int unsigned LIM_EXTRA = 6;
endpackage

// File: rtl/rwm_edge.sv
// Rising-edge detector for a bundle of already-synchronous lines.
// Assumes inputs are sampled on clk; one cycle of latency-free detection.
module rwm_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        // Remember last sampled level of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= sig_in[g];
        end
        // Rise = high now, low at the previous edge.
        assign rise[g] = sig_in[g] & ~prev_q[g];
    end
endmodule

// File: rtl/rwm_limits.sv
// Computes the lower and upper acceptance limits from link configuration.
// Assumes configuration is quasi-static; results are registered once.
module rwm_limits #(
    parameter int unsigned TICK_W = 16,
    parameter int unsigned TOL_W  = 8,
    localparam int unsigned LW    = TICK_W + rwm_pkg::LIM_EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] cfg_rtcal,
    input  logic [TICK_W-1:0] cfg_link_period,
    input  logic [TOL_W-1:0]  cfg_tol,
    input  logic [TICK_W-1:0] cfg_margin,
    output logic [LW-1:0]     lo_lim,
    output logic [LW-1:0]     hi_lim
);
    localparam int unsigned PW = LW + TOL_W;

    logic [LW-1:0] ten_per;
    logic [LW-1:0] nominal;
    logic [PW-1:0] prod;
    logic [LW-1:0] dev;
    logic [LW-1:0] lo_raw;
    logic [LW-1:0] margin_x;
    logic [LW-1:0] lo_next;
    logic [LW-1:0] hi_next;

    // Nominal delay: larger of calibration length and ten link periods.
    always_comb begin
        ten_per = (LW'(cfg_link_period) << 3) + (LW'(cfg_link_period) << 1);
        nominal = (LW'(cfg_rtcal) > ten_per) ? LW'(cfg_rtcal) : ten_per;
    end

    // Tolerance deviation, truncated toward zero.
    always_comb begin
        prod = PW'(nominal) * PW'(cfg_tol);
        dev  = LW'(prod >> TOL_W);
    end

    // Window edges with margin; lower edge clamped at zero.
    always_comb begin
        margin_x = LW'(cfg_margin);
        lo_raw   = nominal - dev;
        lo_next  = (lo_raw > margin_x) ? (lo_raw - margin_x) : '0;
        hi_next  = nominal + dev + margin_x;
    end

    // Register the limits to keep the multiply off the compare path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_lim <= '0;
            hi_lim <= '0;
        end else begin
            lo_lim <= lo_next;
            hi_lim <= hi_next;
        end
    end
endmodule

// File: rtl/rwm_timer.sv
// Delay counter and classifier. Arms on an envelope rise, restarts on
// every later envelope rise, and ends on a response rise or on overrun.
// Assumes hi_lim+1 fits in LW bits (guaranteed by the limit widths).
module rwm_timer #(
    parameter int unsigned LW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          env_rise,
    input  logic          resp_rise,
    input  logic [LW-1:0] lo_lim,
    input  logic [LW-1:0] hi_lim,
    output logic          res_valid,
    output logic          res_early,
    output logic          res_ok,
    output logic          res_late,
    output logic [LW-1:0] res_count,
    output logic          armed
);
    import rwm_pkg::*;

    rwm_state_e    state_q;
    logic [LW-1:0] cnt_q;
    logic          finish;

    // A measurement ends on a reply or once the count has passed the top.
    assign finish = (state_q == ST_ARMED) && !env_rise &&
                    (resp_rise || (cnt_q > hi_lim));
    assign armed  = (state_q == ST_ARMED);

    // State and counter: envelope rise always restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (env_rise) begin
            state_q <= ST_ARMED;
            cnt_q   <= LW'(1);
        end else if (finish) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (state_q == ST_ARMED) begin
            cnt_q   <= cnt_q + LW'(1);
        end
    end

    // Result registers: one-cycle strobe, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !finish) begin
            res_valid <= 1'b0;
            res_early <= 1'b0;
            res_ok    <= 1'b0;
            res_late  <= 1'b0;
            res_count <= '0;
        end else begin
            res_valid <= 1'b1;
            res_early <= (cnt_q < lo_lim);
            res_ok    <= (cnt_q >= lo_lim) && (cnt_q <= hi_lim);
            res_late  <= (cnt_q > hi_lim);
            res_count <= cnt_q;
        end
    end
endmodule

// File: rtl/tag_reply_window_monitor.sv
// Top level: checks the tag reply delay against a run-time window.
// Assumes env_in and resp_in are already synchronous to clk.
module tag_reply_window_monitor #(
    parameter int unsigned TICK_W = 16,
    parameter int unsigned TOL_W  = 8,
    localparam int unsigned LW    = TICK_W + rwm_pkg::LIM_EXTRA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              env_in,
    input  logic              resp_in,
    input  logic [TICK_W-1:0] cfg_rtcal,
    input  logic [TICK_W-1:0] cfg_link_period,
    input  logic [TOL_W-1:0]  cfg_tol,
    input  logic [TICK_W-1:0] cfg_margin,
    output logic              res_valid,
    output logic              res_early,
    output logic              res_ok,
    output logic              res_late,
    output logic [LW-1:0]     res_count
);
    logic [1:0]    rises;
    logic [LW-1:0] lo_lim;
    logic [LW-1:0] hi_lim;
    logic          armed;

    rwm_edge #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({resp_in, env_in}),
        .rise   (rises)
    );

    rwm_limits #(.TICK_W(TICK_W), .TOL_W(TOL_W)) u_limits (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_rtcal       (cfg_rtcal),
        .cfg_link_period (cfg_link_period),
        .cfg_tol         (cfg_tol),
        .cfg_margin      (cfg_margin),
        .lo_lim          (lo_lim),
        .hi_lim          (hi_lim)
    );

    rwm_timer #(.LW(LW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .env_rise  (rises[0]),
        .resp_rise (rises[1]),
        .lo_lim    (lo_lim),
        .hi_lim    (hi_lim),
        .res_valid (res_valid),
        .res_early (res_early),
        .res_ok    (res_ok),
        .res_late  (res_late),
        .res_count (res_count),
        .armed     (armed)
    );
endmodule

// File: rtl/tag_reply_window_monitor_checker.sv
// Property checker for the reply window monitor, bound to the top.
module tag_reply_window_monitor_checker #(
    parameter int unsigned LW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          res_valid,
    input logic          res_early,
    input logic          res_ok,
    input logic          res_late,
    input logic [LW-1:0] res_count,
    input logic [LW-1:0] lo_lim,
    input logic [LW-1:0] hi_lim,
    input logic          armed
);
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_early, res_ok, res_late}) == 1); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ({res_early, res_ok, res_late} == 3'b000) && (res_count == '0)); // R8
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R8
    AST_OK_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ok) |-> (res_count >= lo_lim) && (res_count <= hi_lim)); // R3
    AST_EARLY_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_early) |-> (res_count < lo_lim)); // R4
    AST_LATE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_late) |-> (res_count > hi_lim)); // R5
    AST_LIMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        lo_lim <= hi_lim); // R2
    AST_RESULT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(armed)); // R7
endmodule

bind tag_reply_window_monitor tag_reply_window_monitor_checker #(.LW(LW)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_early (res_early),
    .res_ok    (res_ok),
    .res_late  (res_late),
    .res_count (res_count),
    .lo_lim    (lo_lim),
    .hi_lim    (hi_lim),
    .armed     (armed)
);

// File: tb/tag_reply_window_monitor_tb.sv
module tag_reply_window_monitor_tb;
    localparam int TICK_W = 16;
    localparam int TOL_W  = 8;
    localparam int LW     = TICK_W + 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              env_in = 1'b0;
    logic              resp_in = 1'b0;
    logic [TICK_W-1:0] cfg_rtcal = '0;
    logic [TICK_W-1:0] cfg_link_period = '0;
    logic [TOL_W-1:0]  cfg_tol = '0;
    logic [TICK_W-1:0] cfg_margin = '0;
    logic              res_valid, res_early, res_ok, res_late;
    logic [LW-1:0]     res_count;

    int checks = 0;
    int fails  = 0;
    int exp_lo, exp_hi;

    always #10 clk = ~clk;

    tag_reply_window_monitor #(.TICK_W(TICK_W), .TOL_W(TOL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .env_in(env_in), .resp_in(resp_in),
        .cfg_rtcal(cfg_rtcal), .cfg_link_period(cfg_link_period),
        .cfg_tol(cfg_tol), .cfg_margin(cfg_margin),
        .res_valid(res_valid), .res_early(res_early), .res_ok(res_ok),
        .res_late(res_late), .res_count(res_count)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Window from the requirement formulas (R1, R2).
    task automatic set_cfg(input int rtcal, input int per, input int tol, input int margin);
        int nom, dev;
        @(negedge clk);
        cfg_rtcal = TICK_W'(rtcal); cfg_link_period = TICK_W'(per);
        cfg_tol = TOL_W'(tol); cfg_margin = TICK_W'(margin);
        nom = (rtcal > 10 * per) ? rtcal : 10 * per;
        dev = (nom * tol) / 256;
        exp_lo = (nom - dev > margin) ? nom - dev - margin : 0;
        exp_hi = nom + dev + margin;
        repeat (3) @(negedge clk);
    endtask

    // Class code: 0 early, 1 ok, 2 late.
    task automatic check_result(input string req, input int cls, input int cnt);
        check(res_valid === 1'b1, req, int'(res_valid), 1);
        check(res_count === LW'(cnt), req, int'(res_count), cnt);
        check({res_early, res_ok, res_late} === (3'b100 >> cls), req,
              int'({res_early, res_ok, res_late}), int'(3'b100 >> cls));
        @(negedge clk);
        check(res_valid === 1'b0, "R8", int'(res_valid), 0);
        resp_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Envelope rise, then a reply d edges later; inputs change at negedge.
    task automatic run_reply(input int d, input string req, input int cls);
        env_in = 1'b1;
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            if (i == 1) env_in = 1'b0;
            if (i == d) resp_in = 1'b1;
        end
        @(negedge clk);
        check_result(req, cls, d);
    endtask

    // Envelope rise with no reply: late at upper+1.
    task automatic run_timeout(input string req);
        env_in = 1'b1;
        for (int i = 1; i <= exp_hi + 1; i++) begin
            @(negedge clk);
            if (i == 1) env_in = 1'b0;
            if (i <= exp_hi) check(res_valid === 1'b0, req, int'(res_valid), 0);
        end
        @(negedge clk);
        check_result(req, 2, exp_hi + 1);
    endtask

    // Two envelope rises; count follows the second (R6).
    task automatic run_restart(input int gap, input int d);
        env_in = 1'b1;
        @(negedge clk); env_in = 1'b0;
        repeat (gap - 1) @(negedge clk);
        check(res_valid === 1'b0, "R6", int'(res_valid), 0);
        run_reply(d, "R6", 1);
    endtask

    // Response pulses with nothing armed produce no result (R7).
    task automatic run_idle_resp();
        for (int p = 0; p < 3; p++) begin
            resp_in = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(res_valid === 1'b0 && res_count === '0, "R7", int'(res_valid), 0);
                resp_in = 1'b0;
            end
        end
    endtask

    task automatic run_reset_check();
        repeat (3) @(negedge clk);
        check({res_valid, res_early, res_ok, res_late} === 4'b0, "R9",
              int'({res_valid, res_early, res_ok, res_late}), 0);
        check(res_count === '0, "R9", int'(res_count), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(res_valid === 1'b0, "R9", int'(res_valid), 0);
    endtask

    initial begin
        run_reset_check();
        // Period-dominated window: nominal 30, dev 7, margin 2 -> 21..39 (R1, R2).
        set_cfg(20, 3, 64, 2);
        check(exp_lo == 21 && exp_hi == 39, "R2", exp_lo, 21);
        run_reply(25, "R3", 1);
        run_reply(21, "R3", 1);
        run_reply(39, "R3", 1);
        run_reply(20, "R4", 0);
        run_reply(3,  "R4", 0);
        run_reply(40, "R5", 2);
        run_timeout("R5");
        run_restart(6, 30);
        run_idle_resp();
        // Calibration-dominated window: nominal 50, dev 1, margin 3 -> 46..54 (R1).
        set_cfg(50, 2, 10, 3);
        run_reply(46, "R1", 1);
        run_reply(45, "R4", 0);
        run_reply(54, "R3", 1);
        run_timeout("R5");
        // Clamped lower limit: nominal 10, dev 9, margin 5 -> 0..24 (R2).
        set_cfg(4, 1, 255, 5);
        run_reply(1, "R2", 1);
        run_reply(24, "R2", 1);
        run_timeout("R2");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule